// File: doc/BRIEF.md
# Banked System-Control Register File with Per-Register Write Protection

This block holds the system-control registers of a small multithreaded processor core. A register is picked by a 5-bit register number and a 3-bit sub-select. Together they form an 8-bit flat index, number times eight plus select. Each implemented register has a fixed protection mask. An ordinary software write changes only the bits that are set in that mask. Identification words, configuration fields and other protected fields keep their values.

Three registers describe a hardware thread, and each thread has its own copy of them. Every other register belongs to a virtual processing element. The element that a thread reaches is named in the low nibble of that thread's binding register. A privileged direct-write strobe lets platform code store a full word into any register without the mask. A masked write raises a one-cycle update pulse in the following cycle, so that downstream logic can resample control state. The address-space tag of the requesting thread's element is always driven on its own output.

Top module: `cp0_regbank`

## Requirements
- R1: The flat index is reg_num*8 + reg_sel. The implemented indices are 0, 8, 16, 17, 18, 20, 24, 32, 40, 41, 64, 80, 96, 97, 98, 104, 120, 121, 128, 129, 130, 131, 136, 152 and 200. Any other index reads as zero, ignores writes and raises no update pulse.
- R2: A masked write (wr_en=1, wr_direct=0) stores (wdata & M) | (old & ~M), where M is the register's protection mask.
- R3: The address-translation group has these masks: index 0 = 0x7FFFFFFF, 16 and 24 = 0x3FFFFFFF, 32 = 0xFF800000, 40 = 0x1FFFF800, 41 = 0x10000000, 80 = 0xFFFFFFFF.
- R4: The control group has these masks: 96 = 0xFF78FF17, 97 = 0x000003E0, 98 = 0x0000F3C0, 104 = 0x08C00300, 121 = 0x3FFFF000, 128 = 0x7FFF0007, 130 = 0x7000F000, 152 = 0x7FFF0FFF, 200 = 0x000007FF. The thread registers 17, 18 and 20 have the mask 0xFFFFFFFF.
- R5: Indices 8, 64, 120, 129, 131 and 136 have an all-zero mask, so a masked write leaves them unchanged.
- R6: A direct write (wr_direct=1) stores wdata in full. It takes priority over wr_en when both are high.
- R7: upd_pulse is high for exactly the cycle after a masked write is accepted. It stays low after a direct write and after a rejected access.
- R8: Reset values, all others zero:
  - index 8 = 63
  - index 96 = 0x00400004
  - index 121 = 0x80000000 | CPUNUM_INIT
  - index 120 = PRID_INIT
  - index 128 = CFG_INIT | 0x80000000
  - indices 129, 130 and 131 = CFG1_INIT, CFG2_INIT and CFG3_INIT
  - index 17 of thread t = 0x00008000 for every t other than 0, and 0 for thread 0
  - index 18 of thread t = t << 21, which makes element 0 current
  - index 20 = 0
- R9: Indices 17, 18 and 20 exist once per thread, and the copy is selected by thr.
- R10: Every other implemented index is selected by the element number E held in bits [3:0] of the binding register (index 18) of thr. If E >= NVPE, these accesses read zero, ignore writes and raise no pulse. Thread registers stay accessible.
- R11: asid equals bits [7:0] of index 80 in the element copy of thr. It is zero when that element is out of range.
- R12: rdata is combinational from the current inputs. In a write cycle it shows the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr | input | TW (max(1, clog2(NTHR))) | Requesting thread |
| reg_num | input | 5 | Register number |
| reg_sel | input | 3 | Register sub-select |
| wr_en | input | 1 | Masked write strobe |
| wr_direct | input | 1 | Unmasked direct write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed register |
| asid | output | 8 | Address-space tag of the thread's element |
| upd_pulse | output | 1 | One-cycle pulse after an accepted masked write |

## Verification
A wrong mask or a wrong merge shows on rdata at the first read-back after the write, one cycle later. The readback sweeps over every flat index and both threads catch it there. A corrupted binding register shows at once as zero reads or wrong copies on every per-element register of that thread. It also shows on asid in the same cycle. A wrong pulse condition is caught in the cycle right after each write. A stale or early update of storage breaks the old-value check that is made during every write cycle.

// File: rtl/cp0_pkg.sv
package cp0_pkg;

  localparam int NVSLOT  = 22;  // per-element registers
  localparam int NTSLOT  = 3;   // per-thread registers
  localparam int VS_TAG  = 8;   // element slot of the address-space tag register
  localparam int TS_BIND = 1;   // thread slot of the binding register

  typedef struct packed {
    logic       hit;
    logic       thr;
    logic [4:0] slot;
  } cp0_dec_t;

  function automatic cp0_dec_t cp0_decode(input logic [7:0] f);
    cp0_dec_t d;
    d.hit = 1'b1; d.thr = 1'b0; d.slot = 5'd0;
    case (f)
      8'd0:   d.slot = 5'd0;
      8'd8:   d.slot = 5'd1;
      8'd16:  d.slot = 5'd2;
      8'd24:  d.slot = 5'd3;
      8'd32:  d.slot = 5'd4;
      8'd40:  d.slot = 5'd5;
      8'd41:  d.slot = 5'd6;
      8'd64:  d.slot = 5'd7;
      8'd80:  d.slot = 5'd8;
      8'd96:  d.slot = 5'd9;
      8'd97:  d.slot = 5'd10;
      8'd98:  d.slot = 5'd11;
      8'd104: d.slot = 5'd12;
      8'd120: d.slot = 5'd13;
      8'd121: d.slot = 5'd14;
      8'd128: d.slot = 5'd15;
      8'd129: d.slot = 5'd16;
      8'd130: d.slot = 5'd17;
      8'd131: d.slot = 5'd18;
      8'd136: d.slot = 5'd19;
      8'd152: d.slot = 5'd20;
      8'd200: d.slot = 5'd21;
      8'd17:  begin d.thr = 1'b1; d.slot = 5'd0; end
      8'd18:  begin d.thr = 1'b1; d.slot = 5'd1; end
      8'd20:  begin d.thr = 1'b1; d.slot = 5'd2; end
      default: d.hit = 1'b0;
    endcase
    return d;
  endfunction

  function automatic logic [31:0] cp0_wmask(input logic thr, input logic [4:0] slot);
    if (thr) return 32'hFFFF_FFFF;
    case (slot)
      5'd0:        return 32'h7FFF_FFFF;
      5'd2, 5'd3:  return 32'h3FFF_FFFF;
      5'd4:        return 32'hFF80_0000;
      5'd5:        return 32'h1FFF_F800;
      5'd6:        return 32'h1000_0000;
      5'd8:        return 32'hFFFF_FFFF;
      5'd9:        return 32'hFF78_FF17;
      5'd10:       return 32'h0000_03E0;
      5'd11:       return 32'h0000_F3C0;
      5'd12:       return 32'h08C0_0300;
      5'd14:       return 32'h3FFF_F000;
      5'd15:       return 32'h7FFF_0007;
      5'd17:       return 32'h7000_F000;
      5'd20:       return 32'h7FFF_0FFF;
      5'd21:       return 32'h0000_07FF;
      default:     return 32'h0000_0000;  // read-only slots
    endcase
  endfunction

  function automatic logic [31:0] cp0_merge(input logic [31:0] old_v,
                                            input logic [31:0] new_v,
                                            input logic [31:0] msk);
    return (new_v & msk) | (old_v & ~msk);
  endfunction

  function automatic logic [31:0] cp0_rst(input logic thr, input logic [4:0] slot,
                                          input int copy,
                                          input logic [31:0] prid, input logic [31:0] cfg,
                                          input logic [31:0] cfg1, input logic [31:0] cfg2,
                                          input logic [31:0] cfg3, input logic [9:0] cpunum);
    if (thr) begin
      case (slot)
        5'd0:    return (copy != 0) ? 32'h0000_8000 : 32'h0;
        5'd1:    return 32'(copy) << 21;
        default: return 32'h0;
      endcase
    end
    case (slot)
      5'd1:    return 32'd63;
      5'd9:    return 32'h0040_0004;
      5'd13:   return prid;
      5'd14:   return 32'h8000_0000 | {22'd0, cpunum};
      5'd15:   return cfg | 32'h8000_0000;
      5'd16:   return cfg1;
      5'd17:   return cfg2;
      5'd18:   return cfg3;
      default: return 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/cp0_addr_dec.sv
module cp0_addr_dec
  import cp0_pkg::*;
(
  input  logic [4:0] reg_num,
  input  logic [2:0] reg_sel,
  output logic       hit,
  output logic       is_thr,
  output logic [4:0] slot
);
  cp0_dec_t d;
  always_comb begin
    d      = cp0_decode({reg_num, reg_sel});
    hit    = d.hit;
    is_thr = d.thr;
    slot   = d.slot;
  end
endmodule

// File: rtl/cp0_copy_bank.sv
module cp0_copy_bank
  import cp0_pkg::*;
#(
  parameter bit          THR_BANK    = 1'b0,
  parameter int          NCOPY       = 2,
  parameter int          NSLOT       = NVSLOT,
  parameter logic [31:0] PRID_INIT   = 32'h0,
  parameter logic [31:0] CFG_INIT    = 32'h0,
  parameter logic [31:0] CFG1_INIT   = 32'h0,
  parameter logic [31:0] CFG2_INIT   = 32'h0,
  parameter logic [31:0] CFG3_INIT   = 32'h0,
  parameter logic [9:0]  CPUNUM_INIT = 10'h0,
  localparam int CW = (NCOPY > 1) ? $clog2(NCOPY) : 1,
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1
)(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic                             direct,
  input  logic [CW-1:0]                    copy,
  input  logic [SW-1:0]                    slot,
  input  logic [31:0]                      wdata,
  output logic [NCOPY-1:0][NSLOT-1:0][31:0] q
);
  logic [31:0] cur, msk, nxt;
  logic        wr_ok;

  always_comb begin
    cur   = q[copy][slot];
    msk   = cp0_wmask(THR_BANK, 5'(slot));
    nxt   = direct ? wdata : cp0_merge(cur, wdata, msk);
    wr_ok = we && (int'(copy) < NCOPY) && (int'(slot) < NSLOT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCOPY; c++)
        for (int s = 0; s < NSLOT; s++)
          q[c][s] <= cp0_rst(THR_BANK, 5'(s), c, PRID_INIT, CFG_INIT, CFG1_INIT,
                             CFG2_INIT, CFG3_INIT, CPUNUM_INIT);
    end else if (wr_ok) begin
      q[copy][slot] <= nxt;
    end
  end
endmodule

// File: rtl/cp0_regbank.sv
module cp0_regbank
  import cp0_pkg::*;
#(
  parameter int          NTHR        = 2,
  parameter int          NVPE        = 2,
  parameter logic [31:0] PRID_INIT   = 32'h0001_9A21,
  parameter logic [31:0] CFG_INIT    = 32'h0000_0483,
  parameter logic [31:0] CFG1_INIT   = 32'h3E63_3C9A,
  parameter logic [31:0] CFG2_INIT   = 32'h8000_0000,
  parameter logic [31:0] CFG3_INIT   = 32'h0000_0024,
  parameter logic [9:0]  CPUNUM_INIT = 10'h005,
  localparam int TW  = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int VW  = (NVPE > 1) ? $clog2(NVPE) : 1,
  localparam int TSW = $clog2(NTSLOT),
  localparam int VSW = $clog2(NVSLOT)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] thr,
  input  logic [4:0]    reg_num,
  input  logic [2:0]    reg_sel,
  input  logic          wr_en,
  input  logic          wr_direct,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic [7:0]    asid,
  output logic          upd_pulse
);
  logic                              dec_hit, dec_thr;
  logic [4:0]                        dec_slot;
  logic [NTHR-1:0][NTSLOT-1:0][31:0] tq;
  logic [NVPE-1:0][NVSLOT-1:0][31:0] vq;
  logic                              thr_ok, vpe_ok, acc_ok, any_wr, t_we, v_we;
  logic [TW-1:0]                     thr_i;
  logic [3:0]                        vpe_num;
  logic [VW-1:0]                     vpe_i;

  cp0_addr_dec u_dec (
    .reg_num(reg_num), .reg_sel(reg_sel),
    .hit(dec_hit), .is_thr(dec_thr), .slot(dec_slot)
  );

  // element selection through the requesting thread's binding register
  always_comb begin
    thr_ok  = int'(thr) < NTHR;
    thr_i   = thr_ok ? thr : '0;
    vpe_num = tq[thr_i][TS_BIND][3:0];
    vpe_ok  = thr_ok && (int'(vpe_num) < NVPE);
    vpe_i   = vpe_ok ? vpe_num[VW-1:0] : '0;
    acc_ok  = dec_hit && thr_ok && (dec_thr || vpe_ok);
    any_wr  = wr_en || wr_direct;
    t_we    = acc_ok && dec_thr && any_wr;
    v_we    = acc_ok && !dec_thr && any_wr;
  end

  cp0_copy_bank #(
    .THR_BANK(1'b1), .NCOPY(NTHR), .NSLOT(NTSLOT),
    .PRID_INIT(PRID_INIT), .CFG_INIT(CFG_INIT), .CFG1_INIT(CFG1_INIT),
    .CFG2_INIT(CFG2_INIT), .CFG3_INIT(CFG3_INIT), .CPUNUM_INIT(CPUNUM_INIT)
  ) u_tbank (
    .clk(clk), .rst_n(rst_n), .we(t_we), .direct(wr_direct),
    .copy(thr_i), .slot(dec_slot[TSW-1:0]), .wdata(wdata), .q(tq)
  );

  cp0_copy_bank #(
    .THR_BANK(1'b0), .NCOPY(NVPE), .NSLOT(NVSLOT),
    .PRID_INIT(PRID_INIT), .CFG_INIT(CFG_INIT), .CFG1_INIT(CFG1_INIT),
    .CFG2_INIT(CFG2_INIT), .CFG3_INIT(CFG3_INIT), .CPUNUM_INIT(CPUNUM_INIT)
  ) u_vbank (
    .clk(clk), .rst_n(rst_n), .we(v_we), .direct(wr_direct),
    .copy(vpe_i), .slot(dec_slot[VSW-1:0]), .wdata(wdata), .q(vq)
  );

  always_comb begin
    if (!acc_ok)      rdata = 32'h0;
    else if (dec_thr) rdata = tq[thr_i][dec_slot[TSW-1:0]];
    else              rdata = vq[vpe_i][dec_slot[VSW-1:0]];
    asid = vpe_ok ? vq[vpe_i][VS_TAG][7:0] : 8'h0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) upd_pulse <= 1'b0;
    else        upd_pulse <= acc_ok && wr_en && !wr_direct;
  end

  // ---- last-write capture, brought out for the checks below ----
  logic          lw_v, lw_d, lw_t;
  logic [TW-1:0] lw_tc;
  logic [VW-1:0] lw_vc;
  logic [4:0]    lw_s;
  logic [31:0]   lw_old, lw_data, lw_m, lw_new;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lw_v <= 1'b0; lw_d <= 1'b0; lw_t <= 1'b0; lw_tc <= '0; lw_vc <= '0;
      lw_s <= '0; lw_old <= '0; lw_data <= '0; lw_m <= '0;
    end else begin
      lw_v    <= acc_ok && any_wr;
      lw_d    <= wr_direct;
      lw_t    <= dec_thr;
      lw_tc   <= thr_i;
      lw_vc   <= vpe_i;
      lw_s    <= dec_slot;
      lw_old  <= rdata;
      lw_data <= wdata;
      lw_m    <= cp0_wmask(dec_thr, dec_slot);
    end
  end

  assign lw_new = lw_t ? tq[lw_tc][lw_s[TSW-1:0]] : vq[lw_vc][lw_s[VSW-1:0]];

  AST_LOCKED_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (lw_v && !lw_d) |-> (((lw_new ^ lw_old) & ~lw_m) == 32'h0)); // R2
  AST_OPEN_BITS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (lw_v && !lw_d) |-> (((lw_new ^ lw_data) & lw_m) == 32'h0)); // R2
  AST_DIRECT_FULL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (lw_v && lw_d) |-> (lw_new == lw_data)); // R6
  AST_PULSE_AFTER_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |-> ($past(wr_en) && !$past(wr_direct))); // R7
  AST_ONE_BANK_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({t_we, v_we})); // R9
endmodule

// File: tb/cp0_regbank_test.sv
`timescale 1ns/1ps
module cp0_regbank_test;
  localparam int          NTHR = 2;
  localparam int          NVPE = 2;
  localparam logic [31:0] P_PRID = 32'h00C3_5A17;
  localparam logic [31:0] P_CFG  = 32'h0000_8402;
  localparam logic [31:0] P_CFG1 = 32'h1234_5678;
  localparam logic [31:0] P_CFG2 = 32'h8765_4321;
  localparam logic [31:0] P_CFG3 = 32'h0000_00A4;
  localparam logic [9:0]  P_CPU  = 10'h2A3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [0:0]  thr = '0;
  logic [4:0]  reg_num = '0;
  logic [2:0]  reg_sel = '0;
  logic        wr_en = 1'b0, wr_direct = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  asid;
  logic        upd_pulse;

  int n_chk = 0, n_bad = 0;
  logic [31:0] mt [NTHR][256];
  logic [31:0] mv [NVPE][256];

  always #4 clk = ~clk;  // 125 MHz

  cp0_regbank #(
    .NTHR(NTHR), .NVPE(NVPE), .PRID_INIT(P_PRID), .CFG_INIT(P_CFG),
    .CFG1_INIT(P_CFG1), .CFG2_INIT(P_CFG2), .CFG3_INIT(P_CFG3), .CPUNUM_INIT(P_CPU)
  ) uut (
    .clk(clk), .rst_n(rst_n), .thr(thr), .reg_num(reg_num), .reg_sel(reg_sel),
    .wr_en(wr_en), .wr_direct(wr_direct), .wdata(wdata),
    .rdata(rdata), .asid(asid), .upd_pulse(upd_pulse)
  );

  // ---- reference tables, restated from the requirements ----
  function automatic bit b_thr(int f);
    return (f == 17) || (f == 18) || (f == 20);
  endfunction

  function automatic bit b_impl(int f);
    case (f)
      0, 8, 16, 17, 18, 20, 24, 32, 40, 41, 64, 80, 96, 97, 98, 104,
      120, 121, 128, 129, 130, 131, 136, 152, 200: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] b_mask(int f);
    case (f)
      0: return 32'h7FFFFFFF;  16, 24: return 32'h3FFFFFFF;
      32: return 32'hFF800000; 40: return 32'h1FFFF800;  41: return 32'h10000000;
      80, 17, 18, 20: return 32'hFFFFFFFF;
      96: return 32'hFF78FF17; 97: return 32'h000003E0;  98: return 32'h0000F3C0;
      104: return 32'h08C00300; 121: return 32'h3FFFF000; 128: return 32'h7FFF0007;
      130: return 32'h7000F000; 152: return 32'h7FFF0FFF; 200: return 32'h000007FF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] b_rst(int f, int copy);
    case (f)
      8:   return 32'd63;
      96:  return 32'h0040_0004;
      120: return P_PRID;
      121: return 32'h8000_0000 + {22'd0, P_CPU};
      128: return P_CFG | 32'h8000_0000;
      129: return P_CFG1;
      130: return P_CFG2;
      131: return P_CFG3;
      17:  return (copy == 0) ? 32'h0 : 32'h8000;
      18:  return copy * 32'h0020_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic int b_vpe(int t);
    return int'(mt[t][18][3:0]);
  endfunction

  function automatic bit b_ok(int t, int f);
    return b_impl(f) && (b_thr(f) || (b_vpe(t) < NVPE));
  endfunction

  function automatic logic [31:0] b_get(int t, int f);
    if (!b_ok(t, f)) return 32'h0;
    return b_thr(f) ? mt[t][f] : mv[b_vpe(t)][f];
  endfunction

  function automatic logic [7:0] b_asid(int t);
    return (b_vpe(t) < NVPE) ? mv[b_vpe(t)][80][7:0] : 8'h0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  task automatic rd(int t, int f, string req);
    @(negedge clk);
    thr = 1'(t); reg_num = 5'(f >> 3); reg_sel = 3'(f); wr_en = 0; wr_direct = 0;
    #1;
    check(req, rdata, b_get(t, f));
    check("R11", {24'h0, asid}, {24'h0, b_asid(t)});
  endtask

  task automatic wr(int t, int f, logic [31:0] d, bit direct, string req);
    bit ok;
    logic [31:0] old_v;
    @(negedge clk);
    thr = 1'(t); reg_num = 5'(f >> 3); reg_sel = 3'(f); wdata = d;
    wr_en = !direct; wr_direct = direct;
    ok = b_ok(t, f);
    old_v = b_get(t, f);
    #1;
    check("R12", rdata, old_v);
    @(negedge clk);
    wr_en = 0; wr_direct = 0;
    check("R7", {31'h0, upd_pulse}, {31'h0, ok && !direct});
    if (ok) begin
      logic [31:0] nv;
      nv = direct ? d : ((d & b_mask(f)) | (old_v & ~b_mask(f)));
      if (b_thr(f)) mt[t][f] = nv; else mv[b_vpe(t)][f] = nv;
    end
    rd(t, f, req);
  endtask

  function automatic string ftag(int f);
    if (!b_impl(f)) return "R1";
    if (b_thr(f)) return "R9";
    if (b_mask(f) == 32'h0) return "R5";
    case (f)
      0, 16, 24, 32, 40, 41, 80: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int t = 0; t < NTHR; t++)
      for (int f = 0; f < 256; f++) mt[t][f] = b_rst(f, t);
    for (int v = 0; v < NVPE; v++)
      for (int f = 0; f < 256; f++) mv[v][f] = b_rst(f, 0);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check("R8", {31'h0, upd_pulse}, 32'h0);

    // reset contents, every index, both threads
    for (int t = 0; t < NTHR; t++)
      for (int f = 0; f < 256; f++) rd(t, f, "R8");

    // masked write sweeps (binding register handled separately)
    for (int f = 0; f < 256; f++)
      if (f != 18) wr(0, f, {8'(f), ~8'(f), 8'hA5, 8'(f * 7)}, 1'b0, "R2");
    for (int f = 0; f < 256; f++)
      if (f != 18) wr(1, f, 32'hFFFF_FFFF ^ {8'(f), 16'h3C96, 8'(f)}, 1'b0, ftag(f));

    // direct write sweep on thread 0
    for (int f = 0; f < 256; f++)
      if (f != 18) wr(0, f, {8'h5A, 8'(f), 8'(f + 3), 8'hC3}, 1'b1, "R6");
    // both strobes high: direct wins
    @(negedge clk);
    thr = 0; reg_num = 5'd12; reg_sel = 3'd0; wdata = 32'h0000_0000;
    wr_en = 1; wr_direct = 1;
    @(negedge clk);
    wr_en = 0; wr_direct = 0;
    mv[b_vpe(0)][96] = 32'h0;
    check("R6", {31'h0, upd_pulse}, 32'h0);
    rd(0, 96, "R6");

    // move thread 1 to element 1 and confirm it sees untouched copies
    wr(1, 18, 32'h0020_0001, 1'b1, "R10");
    for (int f = 0; f < 256; f++) rd(1, f, "R10");
    wr(1, 80, 32'h1234_5677, 1'b0, "R11");
    wr(0, 80, 32'h0000_00E1, 1'b0, "R11");
    rd(1, 0, "R11");

    // out-of-range element: element registers dead, thread registers alive
    wr(1, 18, 32'h0020_0003, 1'b0, "R10");
    wr(1, 96, 32'hFFFF_FFFF, 1'b0, "R10");
    wr(1, 80, 32'hFFFF_FFFF, 1'b1, "R10");
    rd(1, 17, "R9");
    wr(1, 20, 32'h0000_0001, 1'b0, "R9");
    rd(0, 20, "R9");
    wr(1, 18, 32'h0020_0001, 1'b1, "R10");
    rd(1, 96, "R10");
    rd(1, 80, "R10");

    finish_run();
  end
endmodule